// File: doc/BRIEF.md
# Subtract-and-Branch-If-Negative Processor

This block is a minimal stored-program machine with exactly one instruction. An instruction is three consecutive memory words holding the addresses a, b and c, and it has no opcode. The machine computes mem[a] - mem[b] in signed 16-bit arithmetic and writes the result back into mem[a]. If that result is negative, control moves to address c. Otherwise control falls through to the next three-word instruction. Program and data share one synchronous, word-addressed RAM inside the block, so a program can rewrite its own instructions.

While reset is held, a load port fills the RAM with a program image. Releasing reset starts execution at address 0. A debug read port can read any RAM word at any time, so results can be inspected after the machine halts. A taken branch to address 0xFF stops the machine. After that it raises `halted` and writes nothing more until the next reset.

The controller is a sequencer with eight named states. Per instruction the path is ST_FETCH_A (read word pc) → ST_FETCH_B (capture a, read pc+1) → ST_FETCH_C (capture b, read pc+2) → ST_LOAD_A (capture c, read mem[a]) → ST_LOAD_B (capture mem[a], read mem[b]) → ST_WRITE (write the difference to mem[a], record its sign) → ST_UPDATE. From ST_UPDATE there are three transitions:
- back to ST_FETCH_A with pc = pc+3 when the result is not negative;
- back to ST_FETCH_A with pc = c when the result is negative and c is not 0xFF;
- to ST_HALT when the result is negative and c is 0xFF.

ST_HALT only transitions to itself, until reset.

Top module: `subneg_core`

## Requirements
- R1: While `rst` is high, `running` and `halted` are low. After reset is released, the first instruction is fetched from address 0.
- R2: While `rst` is high, a cycle with `load_en` high writes `load_data` to `load_addr`. While `rst` is low, the load port has no effect on memory.
- R3: Each instruction stores mem[a] - mem[b], taken modulo 2^16, into mem[a].
- R4: When the stored result is negative (bit 15 set) and c is not 0xFF, the next instruction is fetched from address c.
- R5: When the stored result is zero or positive, the next instruction is fetched from pc+3, taken modulo 256.
- R6: Every instruction takes exactly 7 clock cycles and performs exactly one memory write, in ST_WRITE.
- R7: Instructions are ordinary RAM words. A write by one instruction to a word of a later instruction changes what that later instruction does.
- R8: A negative result with c = 0xFF moves the machine to the halt state. `halted` then rises and stays high, `running` is low, and memory is no longer written, until reset.
- R9: `dbg_data` shows mem[`dbg_addr`] one clock after the address is presented, in any state.
- R10: Only the low 8 bits of each operand word form the address. The upper 8 bits are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; enables the load port |
| load_en | input | 1 | Load write strobe (used only during reset) |
| load_addr | input | 8 | Load word address |
| load_data | input | 16 | Load word value |
| dbg_addr | input | 8 | Debug read address |
| dbg_data | output | 16 | Registered debug read data |
| running | output | 1 | High while executing (not in reset, not halted) |
| halted | output | 1 | High once the halt branch has been taken |

## Verification
The assertions check on every cycle:
- the fixed fetch order and the single write per instruction, made only in ST_WRITE;
- the program counter after ST_UPDATE, which is pc+3 on a non-negative result and c on a taken branch;
- entry into the halt state, that it persists, and that no write occurs once halted.

Only the bench's scenarios can show the remaining behaviour. It loads whole programs, compares the final memory image with an independent interpreter, and measures cycles per instruction. Its programs cover:
- overflow wrap in the subtraction;
- branches that skip code;
- an instruction that rewrites another's branch target;
- operand words with junk in the upper bits;
- load writes that arrive outside reset and must be ignored.

// File: rtl/subneg_pkg.sv
`timescale 1ns/1ps
package subneg_pkg;

    typedef enum logic [2:0] {
        ST_FETCH_A,
        ST_FETCH_B,
        ST_FETCH_C,
        ST_LOAD_A,
        ST_LOAD_B,
        ST_WRITE,
        ST_UPDATE,
        ST_HALT
    } sbn_state_e;

endpackage

// File: rtl/subneg_ram.sv
`timescale 1ns/1ps
module subneg_ram #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata,
    input  logic [ADDR_W-1:0] dbg_addr,
    output logic [DATA_W-1:0] dbg_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // both read ports are registered: one cycle of latency
    always_ff @(posedge clk) begin
        rdata    <= mem[raddr];
        dbg_data <= mem[dbg_addr];
    end

endmodule

// File: rtl/subneg_alu.sv
`timescale 1ns/1ps
module subneg_alu #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] minuend,
    input  logic [DATA_W-1:0] subtrahend,
    output logic [DATA_W-1:0] diff,
    output logic              is_neg
);
    // two's complement subtraction; the carry out is dropped, so it wraps
    always_comb begin
        diff   = minuend - subtrahend;
        is_neg = diff[DATA_W-1];
    end

endmodule

// File: rtl/subneg_fsm.sv
`timescale 1ns/1ps
module subneg_fsm
    import subneg_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] rdata,
    input  logic              alu_neg,
    output logic [ADDR_W-1:0] raddr,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic [DATA_W-1:0] opa,
    output sbn_state_e        state,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] tgt,
    output logic              neg
);
    localparam logic [ADDR_W-1:0] OFS_ONE  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] OFS_TWO  = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] OFS_STEP = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] HALT_TGT = {ADDR_W{1'b1}};

    sbn_state_e        state_q, state_d;
    logic [ADDR_W-1:0] pc_q, a_q, b_q, c_q;
    logic [DATA_W-1:0] opa_q;
    logic              neg_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FETCH_A;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH_A: state_d = ST_FETCH_B;
            ST_FETCH_B: state_d = ST_FETCH_C;
            ST_FETCH_C: state_d = ST_LOAD_A;
            ST_LOAD_A:  state_d = ST_LOAD_B;
            ST_LOAD_B:  state_d = ST_WRITE;
            ST_WRITE:   state_d = ST_UPDATE;
            ST_UPDATE:  state_d = (neg_q && (c_q == HALT_TGT)) ? ST_HALT : ST_FETCH_A;
            ST_HALT:    state_d = ST_HALT;
            default:    state_d = ST_HALT;
        endcase
    end

    // operand, address and program counter registers
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            a_q   <= '0;
            b_q   <= '0;
            c_q   <= '0;
            opa_q <= '0;
            neg_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_FETCH_B: a_q   <= rdata[ADDR_W-1:0];
                ST_FETCH_C: b_q   <= rdata[ADDR_W-1:0];
                ST_LOAD_A:  c_q   <= rdata[ADDR_W-1:0];
                ST_LOAD_B:  opa_q <= rdata;
                ST_WRITE:   neg_q <= alu_neg;
                ST_UPDATE: begin
                    if (!neg_q) begin
                        pc_q <= pc_q + OFS_STEP;
                    end else if (c_q != HALT_TGT) begin
                        pc_q <= c_q;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs: memory requests per state
    always_comb begin
        raddr = pc_q;
        we    = 1'b0;
        waddr = a_q;
        unique case (state_q)
            ST_FETCH_A: raddr = pc_q;
            ST_FETCH_B: raddr = pc_q + OFS_ONE;
            ST_FETCH_C: raddr = pc_q + OFS_TWO;
            ST_LOAD_A:  raddr = a_q;
            ST_LOAD_B:  raddr = b_q;
            ST_WRITE:   we    = 1'b1;
            ST_UPDATE:  raddr = pc_q;
            ST_HALT:    raddr = pc_q;
            default:    raddr = pc_q;
        endcase
    end

    assign opa   = opa_q;
    assign state = state_q;
    assign pc    = pc_q;
    assign tgt   = c_q;
    assign neg   = neg_q;

endmodule

// File: rtl/subneg_core.sv
`timescale 1ns/1ps
module subneg_core
    import subneg_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [DATA_W-1:0] load_data,
    input  logic [ADDR_W-1:0] dbg_addr,
    output logic [DATA_W-1:0] dbg_data,
    output logic              running,
    output logic              halted
);
    logic [ADDR_W-1:0] cpu_raddr, cpu_waddr, fsm_pc, fsm_tgt;
    logic [DATA_W-1:0] cpu_rdata, fsm_opa, alu_diff;
    logic              cpu_we, alu_neg, fsm_neg;
    sbn_state_e        fsm_state;

    logic              ram_we;
    logic [ADDR_W-1:0] ram_waddr;
    logic [DATA_W-1:0] ram_wdata;

    // the load port owns the write side only while reset is held
    always_comb begin
        if (rst) begin
            ram_we    = load_en;
            ram_waddr = load_addr;
            ram_wdata = load_data;
        end else begin
            ram_we    = cpu_we;
            ram_waddr = cpu_waddr;
            ram_wdata = alu_diff;
        end
    end

    always_comb begin
        halted  = (fsm_state == ST_HALT);
        running = !rst && (fsm_state != ST_HALT);
    end

    subneg_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .clk      (clk),
        .we       (ram_we),
        .waddr    (ram_waddr),
        .wdata    (ram_wdata),
        .raddr    (cpu_raddr),
        .rdata    (cpu_rdata),
        .dbg_addr (dbg_addr),
        .dbg_data (dbg_data)
    );

    subneg_alu #(.DATA_W(DATA_W)) u_alu (
        .minuend    (fsm_opa),
        .subtrahend (cpu_rdata),
        .diff       (alu_diff),
        .is_neg     (alu_neg)
    );

    subneg_fsm #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .rdata   (cpu_rdata),
        .alu_neg (alu_neg),
        .raddr   (cpu_raddr),
        .we      (cpu_we),
        .waddr   (cpu_waddr),
        .opa     (fsm_opa),
        .state   (fsm_state),
        .pc      (fsm_pc),
        .tgt     (fsm_tgt),
        .neg     (fsm_neg)
    );

endmodule

// File: rtl/subneg_chk.sv
`timescale 1ns/1ps
module subneg_chk
    import subneg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              running,
    input logic              halted,
    input sbn_state_e        st,
    input logic [ADDR_W-1:0] pc,
    input logic [ADDR_W-1:0] tgt,
    input logic              neg,
    input logic              cpu_we
);
    localparam logic [ADDR_W-1:0] STEP_C = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] ALL1_C = {ADDR_W{1'b1}};

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst) halted |=> halted); // R8
    AST_HALT_NO_WRITE: assert property (@(posedge clk) disable iff (rst) halted |-> !cpu_we); // R8
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(running && halted)); // R1
    AST_FETCH_ORDER: assert property (@(posedge clk) disable iff (rst) (st == ST_FETCH_A) |=> (st == ST_FETCH_B)); // R6
    AST_WRITE_IN_SLOT: assert property (@(posedge clk) disable iff (rst) cpu_we |-> (st == ST_WRITE)); // R6
    AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (rst) cpu_we |=> !cpu_we); // R6
    AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (rst)
        (st == ST_UPDATE && !neg) |=> (pc == $past(pc) + STEP_C) && (st == ST_FETCH_A)); // R5
    AST_BRANCH_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (st == ST_UPDATE && neg && tgt != ALL1_C) |=> (pc == $past(tgt))); // R4
    AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (st == ST_UPDATE && neg && tgt == ALL1_C) |=> halted); // R8

endmodule

bind subneg_core subneg_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .running (running),
    .halted  (halted),
    .st      (fsm_state),
    .pc      (fsm_pc),
    .tgt     (fsm_tgt),
    .neg     (fsm_neg),
    .cpu_we  (cpu_we)
);

// File: tb/sim_subneg_core.sv
`timescale 1ns/1ps
module sim_subneg_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_en = 1'b0;
    logic [7:0]  load_addr = '0;
    logic [15:0] load_data = '0;
    logic [7:0]  dbg_addr = '0;
    logic [15:0] dbg_data;
    logic        running, halted;

    int n_chk  = 0;
    int n_fail = 0;

    logic [15:0] img     [256];
    logic [15:0] ref_mem [256];

    always #2.5 clk = ~clk;

    subneg_core u0 (
        .clk       (clk),
        .rst       (rst),
        .load_en   (load_en),
        .load_addr (load_addr),
        .load_data (load_data),
        .dbg_addr  (dbg_addr),
        .dbg_data  (dbg_data),
        .running   (running),
        .halted    (halted)
    );

    // data cells
    localparam int CX = 100, CY = 101, CT = 102, CH = 103, CZ = 104, C1 = 105;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_img();
        for (int i = 0; i < 256; i++) img[i] = 16'h0000;
        img[CH] = 16'hFFFF;   // constant -1 for the halt instruction
        img[C1] = 16'h0001;
    endtask

    task automatic put_ins(input int at, input logic [15:0] a, input logic [15:0] b,
                           input logic [15:0] c);
        img[at]     = a;
        img[at + 1] = b;
        img[at + 2] = c;
    endtask

    task automatic load_img();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 256; i++) begin
            load_en   = 1'b1;
            load_addr = 8'(i);
            load_data = img[i];
            @(negedge clk);
        end
        load_en = 1'b0;
    endtask

    // independent interpreter of the instruction semantics
    task automatic model(output int n, output bit h);
        logic [7:0]  pc, a, b, c;
        logic [15:0] d;
        for (int i = 0; i < 256; i++) ref_mem[i] = img[i];
        pc = 8'd0; n = 0; h = 1'b0;
        for (int k = 0; k < 2000 && !h; k++) begin
            a = ref_mem[pc][7:0];
            b = ref_mem[8'(pc + 8'd1)][7:0];
            c = ref_mem[8'(pc + 8'd2)][7:0];
            d = ref_mem[a] - ref_mem[b];
            ref_mem[a] = d;
            n++;
            if (d[15]) begin
                if (c == 8'hFF) h = 1'b1;
                else pc = c;
            end else begin
                pc = 8'(pc + 8'd3);
            end
        end
    endtask

    task automatic dbg_read(input logic [7:0] ad, output logic [15:0] v);
        @(negedge clk);
        dbg_addr = ad;
        @(negedge clk);
        v = dbg_data;
    endtask

    task automatic cmp_mem(input string req);
        int bad = 0;
        logic [15:0] v;
        for (int i = 0; i < 256; i++) begin
            dbg_read(8'(i), v);
            if (v !== ref_mem[i]) begin
                bad++;
                if (bad <= 4)
                    $display("FAIL %s mem[%0d] actual=%0h expected=%0h", req, i, v, ref_mem[i]);
            end
        end
        n_chk++;
        if (bad != 0) n_fail++;
    endtask

    // load, release reset, run to halt, check timing and final image
    task automatic exec(input string req);
        int n, cyc;
        bit h;
        load_img();
        model(n, h);
        rst = 1'b0;
        cyc = 0;
        @(negedge clk);
        cyc++;
        chk(running === 1'b1, "R1", "running after release", running, 1);
        while (!halted && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        chk(halted === 1'b1, "R8", {req, " halted"}, halted, 1);
        chk(cyc == 7 * n, "R6", {req, " cycles"}, cyc, 7 * n);
        repeat (10) @(negedge clk);
        chk(halted === 1'b1 && running === 1'b0, "R8", {req, " halt held"},
            {halted, running}, 2'b10);
        cmp_mem(req);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(running === 1'b0, "R1", "running in reset", running, 0);
        chk(halted === 1'b0, "R1", "halted in reset", halted, 0);
    endtask

    task automatic t_add();
        logic [15:0] v;
        clear_img();
        img[CX] = 16'd25;
        img[CY] = 16'd17;
        put_ins(0, CT, CT, 3);      // T = 0
        put_ins(3, CT, CX, 6);      // T = -X
        put_ins(6, CY, CT, 9);      // Y = Y + X
        put_ins(9, CH, CZ, 16'hFF); // halt
        exec("R3 add");
        dbg_read(8'(CY), v);
        chk(v == 16'd42, "R3", "sum via temp", v, 42);
        dbg_read(8'(CT), v);
        chk(v == 16'hFFE7, "R3", "temp negated", v, 16'hFFE7);
        // load port outside reset must not write
        @(negedge clk);
        load_en = 1'b1; load_addr = 8'(CY); load_data = 16'h1234;
        repeat (3) @(negedge clk);
        load_en = 1'b0;
        dbg_read(8'(CY), v);
        chk(v == 16'd42, "R2", "load ignored when not in reset", v, 42);
    endtask

    task automatic t_wrap();
        logic [15:0] v;
        clear_img();
        img[CX] = 16'h7FFF;
        img[CY] = 16'hFFFF;
        put_ins(0, CX, CY, 16'hFF);  // 0x7FFF - (-1) wraps to 0x8000, negative
        exec("R3 wrap");
        dbg_read(8'(CX), v);
        chk(v == 16'h8000, "R3", "overflow wraps", v, 16'h8000);
    endtask

    task automatic t_branch();
        logic [15:0] v;
        clear_img();
        img[CX] = 16'd3;
        img[CY] = 16'd5;
        img[110] = 16'd7;            // marker that must stay
        img[111] = 16'd4;
        put_ins(0, CX, CY, 9);       // -2: branch to 9 (R4)
        put_ins(3, 110, C1, 6);      // skipped
        put_ins(9, 111, CZ, 40);     // 4: not negative, falls to 12 (R5)
        put_ins(12, CH, CZ, 16'hFF);
        exec("R4 R5 branch");
        dbg_read(8'd110, v);
        chk(v == 16'd7, "R4", "skipped instruction untouched", v, 7);
        dbg_read(8'd111, v);
        chk(v == 16'd4, "R5", "zero subtrahend keeps value", v, 4);
    endtask

    task automatic t_selfmod();
        logic [15:0] v;
        clear_img();
        img[CX] = 16'hFFF6;          // -10
        img[120] = 16'd50;           // reached only by the rewritten target
        img[121] = 16'd60;           // reached only by the original target
        put_ins(0, 5, CX, 3);        // word 5 = 20 + 10 = 30
        put_ins(3, CH, CZ, 20);      // branch target rewritten to 30
        put_ins(20, 121, C1, 23);
        put_ins(23, CH, CZ, 16'hFF);
        put_ins(30, 120, C1, 33);
        put_ins(33, CH, CZ, 16'hFF);
        exec("R7 selfmod");
        dbg_read(8'd120, v);
        chk(v == 16'd49, "R7", "rewritten target executed", v, 49);
        dbg_read(8'd121, v);
        chk(v == 16'd60, "R7", "original target not executed", v, 60);
    endtask

    task automatic t_fields();
        logic [15:0] v;
        clear_img();
        img[100] = 16'd5;
        img[101] = 16'd9;
        put_ins(0, 16'hAB64, 16'hCD65, 16'h12FF); // upper bytes are junk
        exec("R10 fields");
        dbg_read(8'd100, v);
        chk(v == 16'hFFFC, "R10", "low byte addresses", v, 16'hFFFC);
    endtask

    task automatic t_debug();
        logic [15:0] v;
        clear_img();
        img[77] = 16'hBEEF;
        img[200] = 16'h0123;
        load_img();            // still in reset
        dbg_read(8'd77, v);
        chk(v == 16'hBEEF, "R9", "debug read 77", v, 16'hBEEF);
        dbg_read(8'd200, v);
        chk(v == 16'h0123, "R2", "load in reset written", v, 16'h0123);
    endtask

    initial begin
        #750000;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_debug();
        t_add();
        t_wrap();
        t_branch();
        t_selfmod();
        t_fields();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule